// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

A compact processor that executes one instruction at a time around a single accumulator. Each 16-bit instruction word holds a 4-bit opcode in its upper bits and a 12-bit direct address in its lower bits. Internally, a program counter, an instruction register, a memory address register and the accumulator are joined by three buses. The address bus loads the memory address register. The memory bus carries memory read data, or the accumulator during a store. The result bus carries the ALU output into the accumulator.

A control state machine splits every instruction into bus micro-operations. It drives each register load, each bus source select, the ALU function and the memory strobe. The sequence is instruction fetch, decode, operand fetch, execute and program-counter increment. The core talks to one synchronous single-port memory. An access is requested with an enable and a read/write line, where 1 means read and 0 means write. Read data comes back on the cycle after the request. The core stops for good when it executes a halt instruction.

Top module: `acc_cpu`

## Requirements
- R1: While the active-low asynchronous reset is low, and on release, the PC, AC, IR and MAR are cleared and halt_o is 0. Memory stays idle (mem_en_o = 0, mem_rnw_o = 1), and execution restarts with a fetch from address 0.
- R2: Each instruction starts with a fetch. The instruction's second cycle issues a read (mem_en_o = 1, mem_rnw_o = 1) at the current PC.
- R3: The opcode is bits [15:12] of the instruction word and the operand address is bits [11:0]. Every operand access uses that address.
- R4: Opcode 0 (LOAD) reads the operand and loads it into AC unchanged.
- R5: Opcode 1 (ADD) reads the operand and sets AC to AC plus the operand, modulo 2^16.
- R6: Opcode 2 (STORE) makes exactly one write cycle (mem_en_o = 1, mem_rnw_o = 0). It writes AC to the operand address on mem_wdata_o.
- R7: Opcode 3 (HALT) raises halt_o after decode. halt_o then stays high, and no further memory access is made until reset.
- R8: Any other opcode makes no access beyond its fetch and leaves AC unchanged. The PC still advances.
- R9: Apart from a HALT, every instruction ends by incrementing the PC by exactly one. The PC never changes in any other way.
- R10: Timing is fixed. LOAD and ADD take 8 cycles, STORE takes 7 and an unknown opcode takes 5. A HALT raises halt_o in its 5th cycle. The operand read comes one cycle after MAR is loaded, and its data is used on the following cycle.
- R11: mem_rnw_o is 0 only in a write cycle, and mem_en_o is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_en_o | output | 1 | Memory access request |
| mem_rnw_o | output | 1 | Access type: 1 read, 0 write |
| mem_addr_o | output | 12 | Memory address (MAR) |
| mem_wdata_o | output | 16 | Write data (memory bus) |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| halt_o | output | 1 | High once HALT has executed |

## Verification
Some properties are checked by assertions on every cycle. halt_o never falls and silences memory. A write never occurs without an enable and never repeats on the next cycle. The PC only ever steps by one. The accumulator changes only when the control unit loads it. Three things only the bench's programs can show. The first is the per-instruction cycle counts and the addresses on the bus. The second is the arithmetic values, including wraparound and a store that rewrites a later instruction. The third is that an unknown opcode has no effect and that reset clears the accumulator mid-program.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'd0;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd1;
  localparam logic [OP_W-1:0] OP_STORE = 4'd2;
  localparam logic [OP_W-1:0] OP_HALT  = 4'd3;

  typedef enum logic [3:0] {
    S_FMAR, S_FRD, S_FIR, S_DEC, S_OMAR, S_ORD, S_EXEC, S_STWR, S_PCINC, S_HALT
  } state_e;

  typedef enum logic { ALU_PASS_B = 1'b0, ALU_ADD = 1'b1 } alu_op_e;

  typedef struct packed {
    logic    pc_to_abus;
    logic    ira_to_abus;
    logic    mar_ld;
    logic    ir_ld;
    logic    ac_ld;
    logic    pc_inc;
    logic    mdr_to_mbus;
    logic    ac_to_mbus;
    logic    mem_en;
    logic    mem_rnw;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD:    y_o = a_i + b_i;
      default:    y_o = b_i;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output ctrl_t           ctrl_o,
  output logic            halt_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FMAR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.mem_rnw = 1'b1;
    ctrl_o.alu_op  = ALU_PASS_B;
    state_d        = state_q;
    unique case (state_q)
      S_FMAR: begin
        ctrl_o.pc_to_abus = 1'b1;
        ctrl_o.mar_ld     = 1'b1;
        state_d           = S_FRD;
      end
      S_FRD: begin
        ctrl_o.mem_en = 1'b1;
        state_d       = S_FIR;
      end
      S_FIR: begin
        ctrl_o.mdr_to_mbus = 1'b1;
        ctrl_o.ir_ld       = 1'b1;
        state_d            = S_DEC;
      end
      S_DEC: begin
        if (opcode_i == OP_LOAD || opcode_i == OP_ADD || opcode_i == OP_STORE)
          state_d = S_OMAR;
        else if (opcode_i == OP_HALT)
          state_d = S_HALT;
        else
          state_d = S_PCINC;
      end
      S_OMAR: begin
        ctrl_o.ira_to_abus = 1'b1;
        ctrl_o.mar_ld      = 1'b1;
        state_d            = (opcode_i == OP_STORE) ? S_STWR : S_ORD;
      end
      S_ORD: begin
        ctrl_o.mem_en = 1'b1;
        state_d       = S_EXEC;
      end
      S_EXEC: begin
        ctrl_o.mdr_to_mbus = 1'b1;
        ctrl_o.ac_ld       = 1'b1;
        ctrl_o.alu_op      = (opcode_i == OP_ADD) ? ALU_ADD : ALU_PASS_B;
        state_d            = S_PCINC;
      end
      S_STWR: begin
        ctrl_o.ac_to_mbus = 1'b1;
        ctrl_o.mem_en     = 1'b1;
        ctrl_o.mem_rnw    = 1'b0;
        state_d           = S_PCINC;
      end
      S_PCINC: begin
        ctrl_o.pc_inc = 1'b1;
        state_d       = S_FMAR;
      end
      S_HALT:  state_d = S_HALT;
      default: state_d = S_FMAR;
    endcase
  end

  assign halt_o = (state_q == S_HALT);

  // one driver per bus at a time
  p_abus_one_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o.pc_to_abus, ctrl_o.ira_to_abus}));
  p_mbus_one_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o.mdr_to_mbus, ctrl_o.ac_to_mbus}));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  output logic [OP_W-1:0]   opcode_o,
  output logic              mem_en_o,
  output logic              mem_rnw_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, ac_q;
  logic [ADDR_W-1:0] abus;
  logic [DATA_W-1:0] mbus, rbus;

  always_comb begin
    abus = '0;
    if (ctrl_i.pc_to_abus)       abus = pc_q;
    else if (ctrl_i.ira_to_abus) abus = ir_q[ADDR_W-1:0];
  end

  always_comb begin
    mbus = '0;
    if (ctrl_i.mdr_to_mbus)     mbus = mem_rdata_i;
    else if (ctrl_i.ac_to_mbus) mbus = ac_q;
  end

  acc_alu #(.W(DATA_W)) u_alu (
    .op_i (ctrl_i.alu_op),
    .a_i  (ac_q),
    .b_i  (mbus),
    .y_o  (rbus)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
    end else begin
      if (ctrl_i.pc_inc) pc_q  <= pc_q + 1'b1;
      if (ctrl_i.mar_ld) mar_q <= abus;
      if (ctrl_i.ir_ld)  ir_q  <= mbus;
      if (ctrl_i.ac_ld)  ac_q  <= rbus;
    end
  end

  assign opcode_o    = ir_q[DATA_W-1 -: OP_W];
  assign mem_en_o    = ctrl_i.mem_en;
  assign mem_rnw_o   = ctrl_i.mem_rnw;
  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbus;

  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_q) |-> pc_q == ADDR_W'($past(pc_q) + 1'b1));
  p_ac_only_on_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ac_q) |-> $past(ctrl_i.ac_ld));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter  int ADDR_W = 12,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_en_o,
  output logic              mem_rnw_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halt_o
);
  ctrl_t           ctrl;
  logic [OP_W-1:0] opcode;

  acc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .ctrl_o   (ctrl),
    .halt_o   (halt_o)
  );

  acc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .opcode_o    (opcode),
    .mem_en_o    (mem_en_o),
    .mem_rnw_o   (mem_rnw_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  p_halt_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  p_halt_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !mem_en_o);
  p_write_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rnw_o |-> mem_en_o);
  p_store_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_rnw_o) |=> mem_rnw_o);
endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MEM_N = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          mem_en, mem_rnw, halt;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  acc_cpu #(.ADDR_W(AW)) u_acc_cpu (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_en_o    (mem_en),
    .mem_rnw_o   (mem_rnw),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .halt_o      (halt)
  );

  // bench memory, loaded through its own port while the core is in reset
  logic [DW-1:0] dmem [MEM_N];
  logic [DW-1:0] ref_mem [MEM_N];
  logic          ld_clr = 1'b0, ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  always @(posedge clk) begin
    if (ld_clr) begin
      for (int i = 0; i < MEM_N; i++) dmem[i] <= '0;
    end else if (ld_en) begin
      dmem[ld_addr] <= ld_data;
    end else if (mem_en && !mem_rnw) begin
      dmem[mem_addr] <= mem_wdata;
    end
    if (mem_en && mem_rnw) mem_rdata <= dmem[mem_addr];
  end

  int n_run = 0, n_fail = 0;

  typedef struct {
    bit            en;
    bit            rnw;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    bit            hlt;
    string         tag;
  } rec_t;
  rec_t exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit en, input bit rnw, input int addr, input int wd,
                      input bit hlt, input string tag);
    rec_t r;
    r.en = en; r.rnw = rnw; r.addr = AW'(addr); r.wd = DW'(wd); r.hlt = hlt; r.tag = tag;
    exp_q.push_back(r);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) ref_mem[i] = '0;
    @(negedge clk); ld_clr = 1'b1;
    @(negedge clk); ld_clr = 1'b0;
  endtask

  task automatic load_word(input int a, input int d);
    ref_mem[a] = DW'(d);
    @(negedge clk); ld_en = 1'b1; ld_addr = AW'(a); ld_data = DW'(d);
    @(negedge clk); ld_en = 1'b0;
  endtask

  // instruction-level reference model producing the expected bus per cycle
  task automatic gen_trace(input int halt_tail);
    int pc = 0, ac = 0, ir, op, a;
    bit done = 0;
    exp_q.delete();
    for (int k = 0; k < 200 && !done; k++) begin
      push(0, 1, 0, 0, 0, "R10");                // fetch: PC -> MAR
      push(1, 1, pc, 0, 0, "R2");                // fetch read at PC
      ir = int'(ref_mem[pc]);
      push(0, 1, 0, 0, 0, "R10");                // IR load
      push(0, 1, 0, 0, 0, "R10");                // decode
      op = (ir >> 12) & 'hF;
      a  = ir & 'hFFF;
      case (op)
        0, 1: begin
          push(0, 1, 0, 0, 0, "R3");
          push(1, 1, a, 0, 0, "R3");             // operand read
          push(0, 1, 0, 0, 0, (op == 0) ? "R4" : "R5");
          ac = (op == 0) ? int'(ref_mem[a]) : ((ac + int'(ref_mem[a])) & 'hFFFF);
          push(0, 1, 0, 0, 0, "R9");
          pc = (pc + 1) & 'hFFF;
        end
        2: begin
          push(0, 1, 0, 0, 0, "R3");
          push(1, 0, a, ac, 0, "R6");            // single write
          ref_mem[a] = DW'(ac);
          push(0, 1, 0, 0, 0, "R9");
          pc = (pc + 1) & 'hFFF;
        end
        3: begin
          for (int h = 0; h < halt_tail; h++) push(0, 1, 0, 0, 1, "R7");
          done = 1;
        end
        default: begin
          push(0, 1, 0, 0, 0, "R8");             // no-op: straight to PC+1
          pc = (pc + 1) & 'hFFF;
        end
      endcase
    end
  endtask

  // called at a falling edge with reset released; compares up to n cycles
  task automatic run_trace(input int n);
    int cnt = 0;
    while (exp_q.size() > 0 && cnt < n) begin
      rec_t r;
      bit ok;
      r = exp_q.pop_front();
      #1;
      ok = (mem_en == r.en) && (halt == r.hlt) &&
           (!r.en || mem_addr == r.addr) &&
           (!(r.en && !r.rnw) || mem_wdata == r.wd);
      check(ok, r.tag, "en/halt/addr/wdata",
            {mem_en, halt, 2'b0, mem_addr, mem_wdata},
            {r.en, r.hlt, 2'b0, r.addr, r.wd});
      check(mem_rnw == r.rnw, "R11", "rnw", 32'(mem_rnw), 32'(r.rnw));
      cnt++;
      @(negedge clk);
    end
    exp_q.delete();
  endtask

  task automatic enter_reset();
    @(negedge clk); rst_ni = 1'b0;
    #1;
    check(!mem_en && mem_rnw && !halt, "R1", "outputs in reset",
          {29'b0, mem_en, mem_rnw, halt}, 32'b010);
  endtask

  task automatic leave_reset();
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // program A: load, add with wrap, stores, unknown opcodes, halt
    enter_reset();
    clear_mem();
    load_word('h000, 'h0100); load_word('h001, 'h1101); load_word('h002, 'h2102);
    load_word('h003, 'h1102); load_word('h004, 'h2103); load_word('h005, 'hF123);
    load_word('h006, 'h7456); load_word('h007, 'h2104); load_word('h008, 'h0105);
    load_word('h009, 'h2106); load_word('h00A, 'h3000);
    load_word('h100, 'hFFFF); load_word('h101, 'h0002);
    load_word('h105, 'h8000); load_word('h106, 'h1111);
    gen_trace(8);
    check(exp_q.size() == 82, "R10", "model length", 32'(exp_q.size()), 32'd82);
    leave_reset();
    run_trace(1000);
    check(dmem['h102] == 16'h0001, "R5", "wrapped sum", 32'(dmem['h102]), 32'h0001);
    check(dmem['h103] == 16'h0002, "R5", "second sum",  32'(dmem['h103]), 32'h0002);
    check(dmem['h104] == 16'h0002, "R8", "AC after no-ops", 32'(dmem['h104]), 32'h0002);
    check(dmem['h106] == 16'h8000, "R4", "loaded value", 32'(dmem['h106]), 32'h8000);
    check(halt == 1'b1, "R7", "halt held", 32'(halt), 32'h1);

    // program B: a store rewrites the next instruction before it is fetched
    enter_reset();
    clear_mem();
    load_word('h000, 'h0200); load_word('h001, 'h2002); load_word('h002, 'h3000);
    load_word('h003, 'h2124); load_word('h004, 'h3000);
    load_word('h200, 'h1123); load_word('h123, 'h0005);
    gen_trace(4);
    leave_reset();
    run_trace(1000);
    check(dmem['h002] == 16'h1123, "R6", "rewritten word", 32'(dmem['h002]), 32'h1123);
    check(dmem['h124] == 16'h1128, "R5", "add via new word", 32'(dmem['h124]), 32'h1128);

    // program A again, interrupted by reset mid-run, then program C
    enter_reset();
    clear_mem();
    load_word('h000, 'h0100); load_word('h001, 'h1101); load_word('h002, 'h2102);
    load_word('h100, 'h1234); load_word('h101, 'h0001);
    gen_trace(0);
    leave_reset();
    run_trace(20);
    enter_reset();
    clear_mem();
    load_word('h000, 'h2300); load_word('h001, 'h3000); load_word('h300, 'hBEEF);
    gen_trace(4);
    leave_reset();
    run_trace(1000);
    check(dmem['h300] == 16'h0000, "R1", "AC cleared by reset", 32'(dmem['h300]), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule